// File: doc/BRIEF.md
# Code Memory Protection and Verify-Encryption Unit

This unit stands between the on-chip code store of an 8-bit microcontroller and the paths that reach that store from outside the chip. It keeps a 64-entry key table and three lock bits. Each access request (verify read, table read issued from external program memory, external code fetch, code write) is granted or refused according to the security level. The security level comes from the lock bits. Verify data leaving the chip is scrambled with the key byte selected by the low address bits.

The lock bits form four cumulative levels. Each higher level removes one more right: first code and key writes, together with table reads from external memory, then verify reads, then execution from external memory. The external-access pin is captured when reset is released. Once any lock is set, later pin changes are ignored. Lock bits and keys survive reset and are cleared only by a full erase.

Every request is answered one clock after it is presented. A refused read returns all ones together with a one-cycle refusal flag.

Top module: `code_guard`

## Requirements
- R1: The key table has 64 bytes. Erase sets every entry to 0xFF. A key write stores `wdata` at index `addr[5:0]`, and only at the open level.
- R2: A verify request at the open or first locked level raises `vfy_ok` one cycle later. It returns `rd_data` = NOT(code byte XOR key[`addr[5:0]`]), so the key pattern repeats every 64 code bytes.
- R3: With every key at 0xFF, verify returns the code byte unchanged. A code byte of 0xFF returns the selected key byte.
- R4: `lock_wr` ORs `wdata[2:0]` into the lock bits (bit0 first lock, bit1 second, bit2 third). Only erase clears them. The level follows the highest set bit: bit2 gives level 4, bit1 gives level 3, bit0 gives level 2, and no bit set gives level 1 (open).
- R5: A table read at the open level raises `tbl_ok` and returns the code byte unscrambled.
- R6: A table read at level 2 or higher returns 0xFF with `tbl_deny` high for one cycle.
- R7: At level 2 or higher, code writes and key writes raise `prog_deny` for one cycle and leave the key table unchanged. At the open level they raise `prog_ok`.
- R8: A verify request at level 3 or 4 returns 0xFF with `vfy_deny` high for one cycle.
- R9: An external fetch request is refused (`xexe_deny`) at level 4 and granted (`xexe_ok`) at every other level.
- R10: `ea_state` takes the pin value on the first clock after reset release. At the open level it then follows the pin one cycle late. At level 2 or higher it holds.
- R11: When verify and table requests coincide, `rd_data` carries the verify result and each request gets its own flag.
- R12: In reset, all flags are low, `rd_data` is 0xFF and `ea_state` is 0. Lock bits and keys keep their values through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_pin | input | 1 | External-access pin |
| addr | input | 16 | Code address; low 6 bits select the key |
| code_byte | input | 8 | Byte read from the code store |
| vfy_req | input | 1 | Verify read request |
| tbl_req | input | 1 | Table read issued from external program memory |
| xexe_req | input | 1 | External code fetch request |
| prog_req | input | 1 | Code store write request |
| key_wr | input | 1 | Key table write request |
| lock_wr | input | 1 | Lock bit programming strobe |
| erase | input | 1 | Full erase of keys and lock bits |
| wdata | input | 8 | Key byte or lock mask |
| rd_data | output | 8 | Returned read data |
| vfy_ok | output | 1 | Verify granted |
| vfy_deny | output | 1 | Verify refused |
| tbl_ok | output | 1 | Table read granted |
| tbl_deny | output | 1 | Table read refused |
| xexe_ok | output | 1 | External fetch granted |
| xexe_deny | output | 1 | External fetch refused |
| prog_ok | output | 1 | Code or key write granted |
| prog_deny | output | 1 | Code or key write refused |
| ea_state | output | 1 | Latched external-access state |

## Verification
The hardest state to reach from the ports is a locked part that passes through reset while the external-access pin changes. Only that sequence shows whether the pin is captured exactly once and then frozen. The stimulus sets a lock bit, drives the pin high and pulses reset. It then drops the pin and confirms that `ea_state` and the table-read refusal are unchanged. A separate erase-and-relock pass sets only the third lock bit, to show that the highest programmed bit decides the level even when the lower bits are clear.

// File: rtl/cg_pkg.sv
package cg_pkg;

   localparam int LOCK_BITS = 3;

   typedef enum logic [1:0] {
      SEC_OPEN  = 2'd0,
      SEC_NOTBL = 2'd1,
      SEC_NOVFY = 2'd2,
      SEC_NOEXT = 2'd3
   } sec_lvl_t;

   // highest programmed bit decides
   function automatic sec_lvl_t lvl_of(input logic [LOCK_BITS-1:0] lb);
      if (lb[2])      return SEC_NOEXT;
      else if (lb[1]) return SEC_NOVFY;
      else if (lb[0]) return SEC_NOTBL;
      else            return SEC_OPEN;
   endfunction

endpackage

// File: rtl/cg_key_array.sv
module cg_key_array #(
   parameter int DATA_W    = 8,
   parameter int KEY_DEPTH = 64,
   localparam int KEY_AW   = $clog2(KEY_DEPTH)
) (
   input  logic              clk,
   input  logic              erase,
   input  logic              wr_en,
   input  logic [KEY_AW-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [KEY_AW-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_key
);

   logic [KEY_DEPTH*DATA_W-1:0] key_flat;

   for (genvar i = 0; i < KEY_DEPTH; i++) begin : g_cell
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (erase)
            q <= '1;
         else if (wr_en && (wr_idx == KEY_AW'(i)))
            q <= wr_data;
      end
      assign key_flat[i*DATA_W +: DATA_W] = q;
   end

   assign rd_key = key_flat[rd_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/cg_lock_ctrl.sv
module cg_lock_ctrl
   import cg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 erase,
   input  logic                 lock_wr,
   input  logic [LOCK_BITS-1:0] lock_set,
   input  logic                 ea_pin,
   output logic [LOCK_BITS-1:0] lb_q,
   output sec_lvl_t             lvl,
   output logic                 ea_state,
   output logic                 ea_armed
);

   // lock bits are non-volatile: untouched by reset
   always_ff @(posedge clk) begin
      if (erase)
         lb_q <= '0;
      else if (lock_wr)
         lb_q <= lb_q | lock_set;
   end

   assign lvl = lvl_of(lb_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_armed <= 1'b1;
         ea_state <= 1'b0;
      end else if (ea_armed) begin
         ea_armed <= 1'b0;
         ea_state <= ea_pin;
      end else if (lvl == SEC_OPEN) begin
         ea_state <= ea_pin;
      end
   end

endmodule

// File: rtl/cg_access_gate.sv
module cg_access_gate
   import cg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sec_lvl_t          lvl,
   input  logic [DATA_W-1:0] code_byte,
   input  logic [DATA_W-1:0] key,
   input  logic              vfy_req,
   input  logic              tbl_req,
   input  logic              xexe_req,
   input  logic              prog_req,
   input  logic              key_wr,
   output logic              key_wr_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              vfy_ok,
   output logic              vfy_deny,
   output logic              tbl_ok,
   output logic              tbl_deny,
   output logic              xexe_ok,
   output logic              xexe_deny,
   output logic              prog_ok,
   output logic              prog_deny
);

   logic              vfy_allow, tbl_allow, prog_allow, ext_allow, any_prog;
   logic [DATA_W-1:0] vfy_word, data_nxt;

   always_comb begin
      vfy_allow  = (lvl == SEC_OPEN) || (lvl == SEC_NOTBL);
      tbl_allow  = (lvl == SEC_OPEN);
      prog_allow = (lvl == SEC_OPEN);
      ext_allow  = (lvl != SEC_NOEXT);
      any_prog   = prog_req | key_wr;
      vfy_word   = ~(code_byte ^ key);
      if (vfy_req)
         data_nxt = vfy_allow ? vfy_word : '1;
      else if (tbl_req)
         data_nxt = tbl_allow ? code_byte : '1;
      else
         data_nxt = '1;
   end

   assign key_wr_en = key_wr & prog_allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '1;
         vfy_ok    <= 1'b0;
         vfy_deny  <= 1'b0;
         tbl_ok    <= 1'b0;
         tbl_deny  <= 1'b0;
         xexe_ok   <= 1'b0;
         xexe_deny <= 1'b0;
         prog_ok   <= 1'b0;
         prog_deny <= 1'b0;
      end else begin
         rd_data   <= data_nxt;
         vfy_ok    <= vfy_req  &  vfy_allow;
         vfy_deny  <= vfy_req  & ~vfy_allow;
         tbl_ok    <= tbl_req  &  tbl_allow;
         tbl_deny  <= tbl_req  & ~tbl_allow;
         xexe_ok   <= xexe_req &  ext_allow;
         xexe_deny <= xexe_req & ~ext_allow;
         prog_ok   <= any_prog &  prog_allow;
         prog_deny <= any_prog & ~prog_allow;
      end
   end

endmodule

// File: rtl/code_guard.sv
module code_guard
   import cg_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int KEY_DEPTH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ea_pin,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] code_byte,
   input  logic              vfy_req,
   input  logic              tbl_req,
   input  logic              xexe_req,
   input  logic              prog_req,
   input  logic              key_wr,
   input  logic              lock_wr,
   input  logic              erase,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              vfy_ok,
   output logic              vfy_deny,
   output logic              tbl_ok,
   output logic              tbl_deny,
   output logic              xexe_ok,
   output logic              xexe_deny,
   output logic              prog_ok,
   output logic              prog_deny,
   output logic              ea_state
);

   localparam int KEY_AW = $clog2(KEY_DEPTH);

   if (KEY_DEPTH != (1 << KEY_AW)) begin : g_bad_depth
      $error("KEY_DEPTH must be a power of two");
   end
   if (ADDR_W <= KEY_AW) begin : g_bad_addr
      $error("ADDR_W must exceed the key index width");
   end
   if (DATA_W < LOCK_BITS) begin : g_bad_data
      $error("DATA_W must hold the lock mask");
   end

   logic [LOCK_BITS-1:0] lb_q;
   sec_lvl_t             lvl;
   logic                 ea_armed;
   logic                 key_wr_en;
   logic [DATA_W-1:0]    key;
   logic                 unused_addr_hi;

   assign unused_addr_hi = ^addr[ADDR_W-1:KEY_AW];

   cg_lock_ctrl u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .erase    (erase),
      .lock_wr  (lock_wr),
      .lock_set (wdata[LOCK_BITS-1:0]),
      .ea_pin   (ea_pin),
      .lb_q     (lb_q),
      .lvl      (lvl),
      .ea_state (ea_state),
      .ea_armed (ea_armed)
   );

   cg_key_array #(
      .DATA_W    (DATA_W),
      .KEY_DEPTH (KEY_DEPTH)
   ) u_keys (
      .clk     (clk),
      .erase   (erase),
      .wr_en   (key_wr_en),
      .wr_idx  (addr[KEY_AW-1:0]),
      .wr_data (wdata),
      .rd_idx  (addr[KEY_AW-1:0]),
      .rd_key  (key)
   );

   cg_access_gate #(
      .DATA_W (DATA_W)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (lvl),
      .code_byte (code_byte),
      .key       (key),
      .vfy_req   (vfy_req),
      .tbl_req   (tbl_req),
      .xexe_req  (xexe_req),
      .prog_req  (prog_req),
      .key_wr    (key_wr),
      .key_wr_en (key_wr_en),
      .rd_data   (rd_data),
      .vfy_ok    (vfy_ok),
      .vfy_deny  (vfy_deny),
      .tbl_ok    (tbl_ok),
      .tbl_deny  (tbl_deny),
      .xexe_ok   (xexe_ok),
      .xexe_deny (xexe_deny),
      .prog_ok   (prog_ok),
      .prog_deny (prog_deny)
   );

endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        lvl,
   input logic [2:0]        lb_q,
   input logic              ea_armed,
   input logic              ea_state,
   input logic              erase,
   input logic [DATA_W-1:0] code_byte,
   input logic              vfy_req,
   input logic              tbl_req,
   input logic              xexe_req,
   input logic              prog_req,
   input logic              key_wr,
   input logic [DATA_W-1:0] rd_data,
   input logic              vfy_ok,
   input logic              vfy_deny,
   input logic              tbl_ok,
   input logic              tbl_deny,
   input logic              xexe_deny,
   input logic              prog_deny
);

   assert_vfy_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(vfy_ok && vfy_deny));

   assert_lock_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(erase) |-> ((lb_q & $past(lb_q)) == $past(lb_q)));

   assert_tbl_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_req && !vfy_req && lvl == 2'd0) |=> (tbl_ok && rd_data == $past(code_byte)));

   assert_tbl_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_req && !vfy_req && lvl != 2'd0) |=> (tbl_deny && !tbl_ok && rd_data == '1));

   assert_prog_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((prog_req || key_wr) && lvl != 2'd0) |=> prog_deny);

   assert_vfy_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vfy_req && lvl >= 2'd2) |=> (vfy_deny && rd_data == '1));

   assert_ext_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xexe_req && lvl == 2'd3) |=> xexe_deny);

   assert_ea_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl != 2'd0 && !ea_armed) |=> $stable(ea_state));

endmodule

bind code_guard cg_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lvl       (lvl),
   .lb_q      (lb_q),
   .ea_armed  (ea_armed),
   .ea_state  (ea_state),
   .erase     (erase),
   .code_byte (code_byte),
   .vfy_req   (vfy_req),
   .tbl_req   (tbl_req),
   .xexe_req  (xexe_req),
   .prog_req  (prog_req),
   .key_wr    (key_wr),
   .rd_data   (rd_data),
   .vfy_ok    (vfy_ok),
   .vfy_deny  (vfy_deny),
   .tbl_ok    (tbl_ok),
   .tbl_deny  (tbl_deny),
   .xexe_deny (xexe_deny),
   .prog_deny (prog_deny)
);

// File: tb/sim_code_guard.sv
`timescale 1ns/1ps
module sim_code_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ea_pin = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  code_byte = '0;
   logic        vfy_req = 0, tbl_req = 0, xexe_req = 0, prog_req = 0;
   logic        key_wr = 0, lock_wr = 0, erase = 0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rd_data;
   logic        vfy_ok, vfy_deny, tbl_ok, tbl_deny, xexe_ok, xexe_deny;
   logic        prog_ok, prog_deny, ea_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   code_guard u0 (.*);

   function automatic logic [7:0] key_of(input int i);
      return 8'((i * 37 + 5) & 8'hFF);
   endfunction

   function automatic logic [7:0] code_of(input int a);
      return 8'((a * 13) & 8'hFF) ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      {vfy_req, tbl_req, xexe_req, prog_req, key_wr, lock_wr, erase} = '0;
   endtask

   // drive one request at a negedge, then sample just after the capturing edge
   task automatic issue(input logic v, input logic t, input logic x, input logic p,
                        input logic k, input logic l, input logic e,
                        input int a, input logic [7:0] c, input logic [7:0] w);
      @(negedge clk);
      vfy_req = v; tbl_req = t; xexe_req = x; prog_req = p;
      key_wr = k; lock_wr = l; erase = e;
      addr = 16'(a); code_byte = c; wdata = w;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
   endtask

   task automatic relock(input logic [7:0] mask);
      issue(0,0,0,0,0,0,1, 0, 8'h00, 8'h00);
      issue(0,0,0,0,0,1,0, 0, 8'h00, mask);
      idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R12: reset state, with erase during reset
      @(negedge clk); erase = 1'b1;
      @(negedge clk); erase = 1'b0;
      #1;
      check(rd_data == 8'hFF, "R12 rd_data in reset", rd_data, 8'hFF);
      check({vfy_ok,vfy_deny,tbl_ok,tbl_deny,xexe_ok,xexe_deny,prog_ok,prog_deny} == 0,
            "R12 flags in reset", 1, 0);
      check(ea_state == 1'b0, "R12 ea_state in reset", ea_state, 0);
      do_reset();

      // R3: all keys unprogrammed -> verify returns code unchanged
      for (int a = 0; a < 64; a++) begin
         issue(1,0,0,0,0,0,0, a, code_of(a), 8'h00);
         check(vfy_ok && rd_data == code_of(a), "R3 plain verify", rd_data, code_of(a));
      end

      // R1 R7: program keys at open level
      for (int i = 0; i < 64; i++) begin
         issue(0,0,0,0,1,0,0, i, 8'h00, key_of(i));
         check(prog_ok && !prog_deny, "R7 key write granted", prog_deny, 0);
      end
      issue(0,0,0,1,0,0,0, 7, 8'h00, 8'h00);
      check(prog_ok, "R7 code write granted", prog_ok, 1);

      // R2: scrambled verify across two 64-byte windows
      for (int a = 0; a < 128; a++) begin
         issue(1,0,0,0,0,0,0, a, code_of(a), 8'h00);
         check(vfy_ok && rd_data == ~(code_of(a) ^ key_of(a % 64)), "R2 verify",
               rd_data, ~(code_of(a) ^ key_of(a % 64)));
      end
      // R3: code byte FF returns key
      for (int a = 0; a < 64; a++) begin
         issue(1,0,0,0,0,0,0, a + 256, 8'hFF, 8'h00);
         check(rd_data == key_of(a), "R3 ff returns key", rd_data, key_of(a));
      end

      // R5: table read at open level
      for (int a = 0; a < 16; a++) begin
         issue(0,1,0,0,0,0,0, a, code_of(a), 8'h00);
         check(tbl_ok && !tbl_deny && rd_data == code_of(a), "R5 table plain", rd_data, code_of(a));
      end
      // R11: coincident verify and table
      issue(1,1,0,0,0,0,0, 3, 8'h3C, 8'h00);
      check(vfy_ok && tbl_ok && rd_data == ~(8'h3C ^ key_of(3)), "R11 verify wins",
            rd_data, ~(8'h3C ^ key_of(3)));
      // R9 at open level
      issue(0,0,1,0,0,0,0, 0, 8'h00, 8'h00);
      check(xexe_ok && !xexe_deny, "R9 ext at level1", xexe_ok, 1);

      // R10: open level tracks pin
      idle(); ea_pin = 1'b1;
      @(posedge clk); #1;
      check(ea_state == 1'b1, "R10 tracks pin high", ea_state, 1);
      idle(); ea_pin = 1'b0;
      @(posedge clk); #1;
      check(ea_state == 1'b0, "R10 tracks pin low", ea_state, 0);

      // R4: first lock bit -> level 2
      issue(0,0,0,0,0,1,0, 0, 8'h00, 8'h01);
      issue(0,1,0,0,0,0,0, 9, code_of(9), 8'h00);
      check(tbl_deny && !tbl_ok && rd_data == 8'hFF, "R6 table denied L2", rd_data, 8'hFF);
      idle();
      @(posedge clk); #1;
      check(!tbl_deny, "R6 deny one cycle", tbl_deny, 0);
      issue(0,0,0,0,1,0,0, 5, 8'h00, 8'h00);
      check(prog_deny && !prog_ok, "R7 key write denied", prog_deny, 1);
      issue(0,0,0,1,0,0,0, 5, 8'h00, 8'h00);
      check(prog_deny, "R7 code write denied", prog_deny, 1);
      issue(1,0,0,0,0,0,0, 5, 8'h00, 8'h00);
      check(vfy_ok && rd_data == ~key_of(5), "R7 R1 key unchanged", rd_data, ~key_of(5));
      issue(0,0,1,0,0,0,0, 0, 8'h00, 8'h00);
      check(xexe_ok, "R9 ext at level2", xexe_ok, 1);

      // R10 R12: pin captured at reset release, then frozen; lock survives reset
      idle(); ea_pin = 1'b1;
      do_reset();
      check(ea_state == 1'b1, "R10 captured at release", ea_state, 1);
      idle(); ea_pin = 1'b0;
      repeat (3) @(posedge clk); #1;
      check(ea_state == 1'b1, "R10 frozen at L2", ea_state, 1);
      issue(0,1,0,0,0,0,0, 1, code_of(1), 8'h00);
      check(tbl_deny, "R12 lock survives reset", tbl_deny, 1);

      // level 3
      issue(0,0,0,0,0,1,0, 0, 8'h00, 8'h02);
      issue(1,0,0,0,0,0,0, 4, code_of(4), 8'h00);
      check(vfy_deny && !vfy_ok && rd_data == 8'hFF, "R8 verify denied L3", rd_data, 8'hFF);
      issue(0,0,1,0,0,0,0, 0, 8'h00, 8'h00);
      check(xexe_ok, "R9 ext at level3", xexe_ok, 1);
      // level 4
      issue(0,0,0,0,0,1,0, 0, 8'h00, 8'h04);
      issue(0,0,1,0,0,0,0, 0, 8'h00, 8'h00);
      check(xexe_deny && !xexe_ok, "R9 ext denied L4", xexe_deny, 1);

      // R4: only the top bit set still gives level 4; lower writes keep it
      relock(8'h04);
      issue(0,0,1,0,0,0,0, 0, 8'h00, 8'h00);
      check(xexe_deny, "R4 bit2 alone -> L4", xexe_deny, 1);
      issue(1,0,0,0,0,0,0, 2, 8'h11, 8'h00);
      check(vfy_deny, "R4 bit2 alone blocks verify", vfy_deny, 1);
      issue(0,0,0,0,0,1,0, 0, 8'h00, 8'h00);
      issue(0,0,1,0,0,0,0, 0, 8'h00, 8'h00);
      check(xexe_deny, "R4 empty mask keeps lock", xexe_deny, 1);
      relock(8'h02);
      issue(0,0,1,0,0,0,0, 0, 8'h00, 8'h00);
      check(xexe_ok, "R4 bit1 alone -> L3 ext ok", xexe_ok, 1);
      issue(1,0,0,0,0,0,0, 2, 8'h11, 8'h00);
      check(vfy_deny, "R4 bit1 alone -> L3", vfy_deny, 1);

      // R1: erase restores all keys to FF and opens the part
      relock(8'h00);
      for (int a = 0; a < 64; a++) begin
         issue(1,0,0,0,0,0,0, a, code_of(a), 8'h00);
         check(vfy_ok && rd_data == code_of(a), "R1 erased keys", rd_data, code_of(a));
      end
      issue(0,1,0,0,0,0,0, 8, code_of(8), 8'h00);
      check(tbl_ok && rd_data == code_of(8), "R4 erase reopens", rd_data, code_of(8));
      issue(0,0,0,0,0,0,0, 0, 8'h00, 8'h00);
      check(rd_data == 8'hFF && !tbl_ok, "R12 idle returns ff", rd_data, 8'hFF);

      idle();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule